// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers a parameterised number of level-sensitive interrupt lines, grouped into banks of 32, and drives a single interrupt output toward one processor. Software reaches it through a simple word-addressed register bus. Each line has a mask bit and an 8-bit level register that carries its priority. The block picks the pending, unmasked line with the best priority and latches its number in a status register. It then raises the output and holds that choice until software writes an acknowledge.

Mask bits can be changed in three ways: a direct write of the whole bank word, a write-one-to-set alias, and a write-one-to-clear alias. A per-bank pending register shows which asserted lines are unmasked. A priority threshold can hold back lines whose priority is not good enough. A soft reset returns all state to its reset values and shows its progress through a completion flag. The autoidle bit, the protection register, the idle register and the low two bits of each level register are stored and read back, but they change nothing.

Top module: `bank_irq_ctrl`

## Requirements
- R1: After reset the block is in this state:
  - every line is masked, so each mask register reads 0xFFFFFFFF;
  - every level register reads 0 and the threshold at 0x68 reads 0xFF;
  - irq_o is low and the status register at 0x40 reads 0;
  - the system status register at 0x14 reads 1 and the configuration register at 0x10 reads 0;
  - the revision register at 0x00 reads {major[7:4], minor[3:0]}.
- R2: The masks of bank b are reached through three addresses:
  - 0x84 + 0x20*b reads the mask word and replaces it on a write;
  - a write to 0x8C + 0x20*b masks every line whose data bit is 1;
  - a write to 0x88 + 0x20*b unmasks every line whose data bit is 1;
  - data bits written as 0 through either alias leave their mask bits unchanged.
- R3: The pending register of bank b at 0x98 + 0x20*b reads, bit for bit, input high AND not masked. It follows the inputs in the same cycle.
- R4: The level register of line i sits at 0x100 + 4*i, and bits 7:2 hold its priority, with 0 the best. Among pending unmasked lines the one with the numerically lowest priority is chosen. On equal priority the lower line number wins.
- R5: One clock edge after a line becomes eligible, with no interrupt held, irq_o rises. At the same time the status register latches bit 31 = 1 and the line number in its low bits. The status stays frozen until the acknowledge, even if the line drops or a better line arrives.
- R6: A write to 0x48 with data bit 0 = 1 takes effect at that write's clock edge: irq_o falls and the status register reads 0. A fresh selection happens at the edge after. A write with bit 0 = 0 has no effect.
- R7: A line may be selected only when its priority, zero-extended to 8 bits, is below the threshold. A threshold of 0xFF turns the check off.
- R8: Inputs are level-sensitive. A line that went low before it was unmasked is never selected. A line still high after an acknowledge is selected again.
- R9: A write to 0x10 with bit 1 set returns all state to the R1 values at once. After that, 0x14 bit 0 reads 0 for SRST_CYCLES cycles and then reads 1 again. Bus writes made while it reads 0 are ignored.
- R10: These values are stored and read back but do not change selection:
  - the autoidle bit, bit 0 of 0x10;
  - the protection register at 0x4C, low 8 bits;
  - the idle register at 0x50, low 8 bits;
  - bits 1:0 of each level register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32*N_BANKS | Level-sensitive interrupt lines |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | ADDR_W | Byte address, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from bus_addr_i |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions rely on a few facts about the inputs:
- the interrupt lines are synchronous to clk_i;
- each bus access names one word-aligned address, so no two register writes fire in the same cycle.

The stimulus keeps within these limits. Inputs and bus signals change only at falling edges. Every address is produced by the bench's own aligned offset arithmetic. Random interrupt patterns are applied only after an acknowledge and after any mask and level programming are done, so each latched choice can be predicted from a stable set of inputs.

// File: rtl/bank_irq_pkg.sv
package bank_irq_pkg;
  localparam int unsigned OFS_REV    = 32'h000;
  localparam int unsigned OFS_CFG    = 32'h010;
  localparam int unsigned OFS_STAT   = 32'h014;
  localparam int unsigned OFS_SIR    = 32'h040;
  localparam int unsigned OFS_ACK    = 32'h048;
  localparam int unsigned OFS_PROT   = 32'h04C;
  localparam int unsigned OFS_IDLE   = 32'h050;
  localparam int unsigned OFS_THR    = 32'h068;
  localparam int unsigned OFS_MASK   = 32'h084;
  localparam int unsigned OFS_MCLR   = 32'h088;
  localparam int unsigned OFS_MSET   = 32'h08C;
  localparam int unsigned OFS_PEND   = 32'h098;
  localparam int unsigned BANK_STEP  = 32'h020;
  localparam int unsigned OFS_LVL    = 32'h100;
  localparam int unsigned LINES_PER_BANK = 32;
  localparam logic [7:0]  THR_OFF    = 8'hFF;

  typedef logic [5:0] prio_t;
endpackage

// File: rtl/bank_irq_mask.sv
module bank_irq_mask (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_all_i,
  input  logic        wr_mask_i,
  input  logic        wr_set_i,
  input  logic        wr_clr_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] irq_i,
  output logic [31:0] mask_o,
  output logic [31:0] pend_o
);
  logic [31:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '1;
    else if (clr_all_i) mask_q <= '1;
    else if (wr_mask_i) mask_q <= wdata_i;
    else if (wr_set_i)  mask_q <= mask_q | wdata_i;
    else if (wr_clr_i)  mask_q <= mask_q & ~wdata_i;
  end

  assign mask_o = mask_q;
  assign pend_o = irq_i & ~mask_q;

  // R2
  a_r2_set_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_set_i && !wr_mask_i && !clr_all_i) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  // R2
  a_r2_clr_unmasks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr_i && !wr_set_i && !wr_mask_i && !clr_all_i) |=> ((mask_q & $past(wdata_i)) == 32'h0));
  // R2
  a_r2_zero_bits_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_set_i || wr_clr_i) && !wr_mask_i && !clr_all_i)
      |=> ((mask_q & ~$past(wdata_i)) == ($past(mask_q) & ~$past(wdata_i))));
endmodule

// File: rtl/bank_irq_pick.sv
module bank_irq_pick
  import bank_irq_pkg::*;
#(
  parameter int unsigned N_IRQ = 64,
  localparam int unsigned ID_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] pend_i,
  input  prio_t            prio_i [N_IRQ],
  output logic             found_o,
  output logic [ID_W-1:0]  id_o,
  output prio_t            prio_o
);
  // strict compare keeps the lowest index on ties
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    prio_o  = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (pend_i[i] && (!found_o || prio_i[i] < prio_o)) begin
        found_o = 1'b1;
        id_o    = ID_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl
  import bank_irq_pkg::*;
#(
  parameter int unsigned N_BANKS     = 2,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SRST_CYCLES = 4,
  parameter logic [3:0]  REV_MAJOR   = 4'h2,
  parameter logic [3:0]  REV_MINOR   = 4'h1,
  localparam int unsigned N_IRQ = LINES_PER_BANK * N_BANKS,
  localparam int unsigned ID_W  = $clog2(N_IRQ),
  localparam int unsigned CNT_W = $clog2(SRST_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] srst_cnt_q;
  logic             rst_busy, wr, srst, ack;
  logic             autoidle_q, busy_q;
  logic [7:0]       prot_q, idle_q, thr_q;
  logic [7:0]       lvl_q [N_IRQ];
  logic [ID_W-1:0]  sir_id_q;
  logic [31:0]      mask_w [N_BANKS];
  logic [31:0]      pend_w [N_BANKS];
  logic [N_IRQ-1:0] pend_flat;
  prio_t            prio_w [N_IRQ];
  logic             pick_found, thr_ok;
  logic [ID_W-1:0]  pick_id;
  prio_t            pick_prio;
  logic [ADDR_W-1:0] lvl_off;
  logic             lvl_hit;
  logic [ID_W-1:0]  lvl_idx;

  assign rst_busy = (srst_cnt_q != '0);
  assign wr       = bus_req_i && bus_we_i && !rst_busy;
  assign srst     = wr && (bus_addr_i == ADDR_W'(OFS_CFG)) && bus_wdata_i[1];
  assign ack      = wr && (bus_addr_i == ADDR_W'(OFS_ACK)) && bus_wdata_i[0];

  assign lvl_off  = bus_addr_i - ADDR_W'(OFS_LVL);
  assign lvl_hit  = (bus_addr_i >= ADDR_W'(OFS_LVL)) &&
                    (lvl_off < ADDR_W'(4 * N_IRQ)) && (lvl_off[1:0] == 2'b00);
  assign lvl_idx  = lvl_off[ID_W+1:2];

  // soft reset countdown
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       srst_cnt_q <= '0;
    else if (srst)     srst_cnt_q <= CNT_W'(SRST_CYCLES);
    else if (rst_busy) srst_cnt_q <= srst_cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      autoidle_q <= 1'b0;
      prot_q     <= '0;
      idle_q     <= '0;
      thr_q      <= THR_OFF;
      for (int i = 0; i < N_IRQ; i++) lvl_q[i] <= '0;
    end else if (srst) begin
      autoidle_q <= 1'b0;
      prot_q     <= '0;
      idle_q     <= '0;
      thr_q      <= THR_OFF;
      for (int i = 0; i < N_IRQ; i++) lvl_q[i] <= '0;
    end else if (wr) begin
      if (bus_addr_i == ADDR_W'(OFS_CFG))  autoidle_q <= bus_wdata_i[0];
      if (bus_addr_i == ADDR_W'(OFS_PROT)) prot_q     <= bus_wdata_i[7:0];
      if (bus_addr_i == ADDR_W'(OFS_IDLE)) idle_q     <= bus_wdata_i[7:0];
      if (bus_addr_i == ADDR_W'(OFS_THR))  thr_q      <= bus_wdata_i[7:0];
      if (lvl_hit)                         lvl_q[lvl_idx] <= bus_wdata_i[7:0];
    end
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    localparam int unsigned BOFS = b * BANK_STEP;
    bank_irq_mask u_mask (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_all_i (srst),
      .wr_mask_i (wr && (bus_addr_i == ADDR_W'(OFS_MASK + BOFS))),
      .wr_set_i  (wr && (bus_addr_i == ADDR_W'(OFS_MSET + BOFS))),
      .wr_clr_i  (wr && (bus_addr_i == ADDR_W'(OFS_MCLR + BOFS))),
      .wdata_i   (bus_wdata_i),
      .irq_i     (irq_i[LINES_PER_BANK*b +: LINES_PER_BANK]),
      .mask_o    (mask_w[b]),
      .pend_o    (pend_w[b])
    );
    assign pend_flat[LINES_PER_BANK*b +: LINES_PER_BANK] = pend_w[b];
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_prio
    assign prio_w[i] = lvl_q[i][7:2];
  end

  bank_irq_pick #(.N_IRQ(N_IRQ)) u_pick (
    .pend_i  (pend_flat),
    .prio_i  (prio_w),
    .found_o (pick_found),
    .id_o    (pick_id),
    .prio_o  (pick_prio)
  );

  assign thr_ok = (thr_q == THR_OFF) || ({2'b00, pick_prio} < thr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      sir_id_q <= '0;
    end else if (srst || (busy_q && ack)) begin
      busy_q   <= 1'b0;
      sir_id_q <= '0;
    end else if (!busy_q && !rst_busy && pick_found && thr_ok) begin
      busy_q   <= 1'b1;
      sir_id_q <= pick_id;
    end
  end

  assign irq_o = busy_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(OFS_REV))  bus_rdata_o = {24'h0, REV_MAJOR, REV_MINOR};
    if (bus_addr_i == ADDR_W'(OFS_CFG))  bus_rdata_o = {31'h0, autoidle_q};
    if (bus_addr_i == ADDR_W'(OFS_STAT)) bus_rdata_o = {31'h0, !rst_busy};
    if (bus_addr_i == ADDR_W'(OFS_SIR))  bus_rdata_o = {busy_q, (31-ID_W)'(0), sir_id_q};
    if (bus_addr_i == ADDR_W'(OFS_PROT)) bus_rdata_o = {24'h0, prot_q};
    if (bus_addr_i == ADDR_W'(OFS_IDLE)) bus_rdata_o = {24'h0, idle_q};
    if (bus_addr_i == ADDR_W'(OFS_THR))  bus_rdata_o = {24'h0, thr_q};
    for (int b = 0; b < N_BANKS; b++) begin
      if (bus_addr_i == ADDR_W'(OFS_MASK + b*BANK_STEP)) bus_rdata_o = mask_w[b];
      if (bus_addr_i == ADDR_W'(OFS_PEND + b*BANK_STEP)) bus_rdata_o = pend_w[b];
    end
    if (lvl_hit) bus_rdata_o = {24'h0, lvl_q[lvl_idx]};
  end

  // R4
  a_r4_pick_is_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_found |-> pend_flat[pick_id]);
  // R5
  a_r5_latch_matches_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(pick_found) && ($past(pick_id) == sir_id_q)));
  // R5
  a_r5_status_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ack && !srst) |=> (busy_q && $stable(sir_id_q)));
  // R6
  a_r6_ack_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ack) |=> !irq_o);
  // R7
  a_r7_threshold_met: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (($past(thr_q) == THR_OFF) || ({2'b00, $past(pick_prio)} < $past(thr_q))));
  // R9
  a_r9_srst_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (rst_busy && !irq_o));
  // R9
  a_r9_writes_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_busy |=> $stable(thr_q));
endmodule

// File: tb/test_bank_irq_ctrl.sv
module test_bank_irq_ctrl;
  localparam int NB = 2;
  localparam int N = 32 * NB;
  localparam int SRST = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic          irq_out;
  int            checks = 0, errors = 0;

  logic [N-1:0]  m_mask;
  logic [7:0]    m_lvl [N];
  logic [7:0]    m_thr;

  always #10 clk = ~clk;

  bank_irq_ctrl #(.N_BANKS(NB), .SRST_CYCLES(SRST)) i_bank_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic chk_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    addr = a; req = 1'b1; we = 1'b0;
    #1;
    check(tag, rdata, exp);
    req = 1'b0;
  endtask

  task automatic m_clr(input int b, input logic [31:0] v);
    wr(12'(32'h88 + 32*b), v);
    m_mask[32*b +: 32] = m_mask[32*b +: 32] & ~v;
  endtask

  task automatic m_set(input int b, input logic [31:0] v);
    wr(12'(32'h8C + 32*b), v);
    m_mask[32*b +: 32] = m_mask[32*b +: 32] | v;
  endtask

  task automatic set_lvl(input int i, input logic [7:0] v);
    wr(12'(32'h100 + 4*i), {24'h0, v});
    m_lvl[i] = v;
  endtask

  task automatic set_thr(input logic [7:0] v);
    wr(12'h068, {24'h0, v});
    m_thr = v;
  endtask

  task automatic settle();
    @(negedge clk);
    irq = '0;
    wr(12'h048, 32'h1);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_sir(input logic [N-1:0] pend);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (pend[i] && (best < 0 || m_lvl[i][7:2] < m_lvl[best][7:2])) best = i;
    if (best < 0) return 32'h0;
    if (m_thr != 8'hFF && {2'b00, m_lvl[best][7:2]} >= m_thr) return 32'h0;
    return 32'h8000_0000 | 32'(best);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r1, r2, e;
    void'($urandom(32'd4711));
    m_mask = '1; m_thr = 8'hFF;
    for (int i = 0; i < N; i++) m_lvl[i] = 8'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_rd("R1 revision", 12'h000, 32'h21);
    chk_rd("R1 mask bank0", 12'h084, 32'hFFFF_FFFF);
    chk_rd("R1 mask bank1", 12'h0A4, 32'hFFFF_FFFF);
    chk_rd("R1 threshold", 12'h068, 32'hFF);
    chk_rd("R1 sysstatus done", 12'h014, 32'h1);
    chk_rd("R1 sysconfig", 12'h010, 32'h0);
    chk_rd("R1 status", 12'h040, 32'h0);
    chk_rd("R1 level 5", 12'h114, 32'h0);
    check("R1 irq_o", {31'h0, irq_out}, 32'h0);

    // R2 mask aliases
    m_clr(0, 32'h0000_00F0);
    chk_rd("R2 clear alias", 12'h084, 32'hFFFF_FF0F);
    m_set(0, 32'h0000_0030);
    chk_rd("R2 set alias", 12'h084, 32'hFFFF_FF3F);
    wr(12'h0A4, 32'h1234_5678); m_mask[63:32] = 32'h1234_5678;
    chk_rd("R2 direct write", 12'h0A4, 32'h1234_5678);
    m_clr(1, 32'h0000_0008);
    chk_rd("R2 clear keeps zeros", 12'h0A4, 32'h1234_5670);
    m_set(0, 32'hFFFF_FFFF); m_set(1, 32'hFFFF_FFFF);
    chk_rd("R2 all masked", 12'h0A4, 32'hFFFF_FFFF);

    // R3 pending per bank
    m_clr(0, 32'h0000_FF00); m_clr(1, 32'hF000_0000);
    @(negedge clk); irq = {32'hA000_0001, 32'h0000_0F0F};
    chk_rd("R3 pending bank0", 12'h098, 32'h0000_0F00);
    chk_rd("R3 pending bank1", 12'h0B8, 32'hA000_0000);
    settle();
    m_set(0, 32'hFFFF_FFFF); m_set(1, 32'hFFFF_FFFF);
    chk_rd("R6 status cleared", 12'h040, 32'h0);

    // R4 priority and tie order
    set_lvl(10, 8'h14); set_lvl(40, 8'h14); set_lvl(7, 8'h24);
    m_clr(0, 32'h0000_0480); m_clr(1, 32'h0000_0100);
    @(negedge clk);
    irq[7] = 1'b1; irq[10] = 1'b1; irq[40] = 1'b1;
    tick();
    check("R4 irq_o raised", {31'h0, irq_out}, 32'h1);
    chk_rd("R4 tie to lower line", 12'h040, 32'h8000_000A);
    wr(12'h048, 32'h1);
    check("R6 irq_o after ack", {31'h0, irq_out}, 32'h0);
    chk_rd("R6 status after ack", 12'h040, 32'h0);
    tick();
    chk_rd("R8 still high reselected", 12'h040, 32'h8000_000A);
    irq[10] = 1'b0;
    wr(12'h048, 32'h1); tick();
    chk_rd("R4 equal prio next", 12'h040, 32'h8000_0028);
    irq[40] = 1'b0;
    wr(12'h048, 32'h1); tick();
    chk_rd("R4 worse prio last", 12'h040, 32'h8000_0007);

    // R5 frozen while held
    m_clr(0, 32'h0000_0004);
    @(negedge clk); irq[2] = 1'b1;
    tick(); tick();
    chk_rd("R5 frozen on better line", 12'h040, 32'h8000_0007);
    irq[7] = 1'b0;
    tick();
    chk_rd("R5 frozen on drop", 12'h040, 32'h8000_0007);
    check("R5 irq_o held", {31'h0, irq_out}, 32'h1);
    wr(12'h048, 32'hFFFF_FFFE);
    chk_rd("R6 ack bit0 zero ignored", 12'h040, 32'h8000_0007);
    wr(12'h048, 32'h1); tick();
    chk_rd("R5 next after ack", 12'h040, 32'h8000_0002);
    settle();

    // R7 threshold
    set_lvl(2, 8'h10); set_thr(8'h04);
    @(negedge clk); irq[2] = 1'b1;
    tick(); tick();
    check("R7 prio equal thr blocked", {31'h0, irq_out}, 32'h0);
    chk_rd("R7 status empty", 12'h040, 32'h0);
    set_lvl(2, 8'h0C); tick();
    chk_rd("R7 prio below thr", 12'h040, 32'h8000_0002);
    settle(); set_thr(8'hFF);

    // R8 line dropped before unmask
    @(negedge clk); irq[20] = 1'b1;
    tick();
    irq[20] = 1'b0;
    m_clr(0, 32'h0010_0000);
    tick();
    check("R8 dropped line ignored", {31'h0, irq_out}, 32'h0);
    chk_rd("R3 pending follows level", 12'h098, 32'h0);

    // R10 stored-only fields
    wr(12'h010, 32'h1);
    chk_rd("R10 autoidle readback", 12'h010, 32'h1);
    wr(12'h04C, 32'h5A);
    chk_rd("R10 protection readback", 12'h04C, 32'h5A);
    wr(12'h050, 32'h3);
    chk_rd("R10 idle readback", 12'h050, 32'h3);
    set_lvl(2, 8'h0F);
    chk_rd("R10 level low bits", 12'h108, 32'h0F);
    @(negedge clk); irq[2] = 1'b1;
    tick();
    chk_rd("R10 selection unaffected", 12'h040, 32'h8000_0002);
    settle();

    // random mix, R3 R4 R5 R7
    for (int it = 0; it < 40; it++) begin
      settle();
      for (int k = 0; k < 6; k++) set_lvl(int'($urandom_range(N-1)), 8'($urandom));
      for (int b = 0; b < NB; b++) begin
        r1 = $urandom; r2 = $urandom & $urandom;
        m_clr(b, r1); m_set(b, r2);
      end
      set_thr(($urandom_range(3) == 0) ? 8'($urandom_range(63)) : 8'hFF);
      @(negedge clk);
      irq = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      e = exp_sir(irq & ~m_mask);
      tick();
      chk_rd("R4 random status", 12'h040, e);
      check("R7 random irq_o", {31'h0, irq_out}, {31'h0, e[31]});
      chk_rd("R3 random pend0", 12'h098, irq[31:0] & ~m_mask[31:0]);
      chk_rd("R3 random pend1", 12'h0B8, irq[63:32] & ~m_mask[63:32]);
    end
    settle();

    // R9 soft reset
    set_thr(8'h10); m_clr(0, 32'hFFFF_FFFF); set_lvl(3, 8'h04);
    @(negedge clk); irq[3] = 1'b1;
    tick();
    check("R9 irq before reset", {31'h0, irq_out}, 32'h1);
    wr(12'h010, 32'h2);
    chk_rd("R9 done low", 12'h014, 32'h0);
    check("R9 irq_o cleared", {31'h0, irq_out}, 32'h0);
    wr(12'h068, 32'h33);
    repeat (SRST + 2) @(negedge clk);
    chk_rd("R9 done again", 12'h014, 32'h1);
    chk_rd("R9 write ignored thr", 12'h068, 32'hFF);
    chk_rd("R9 masks restored", 12'h084, 32'hFFFF_FFFF);
    chk_rd("R9 level restored", 12'h10C, 32'h0);
    chk_rd("R9 cfg restored", 12'h010, 32'h0);
    chk_rd("R9 status empty", 12'h040, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule